// File: doc/BRIEF.md
# Remappable On-Chip Memory Address Decoder

This block decodes accesses into a 256 MB internal address region that is divided into 1 MB slots. Each on-chip memory owns one slot. A memory that is smaller than 1 MB appears again and again across its slot, so the decoder passes on the address folded to the size of that memory. Slots that have no memory behind them raise an abort to the bus master. The decoder is combinational. Its only state is a single remap bit.

Slot 0 is a switchable alias. Before remap it shows either the boot ROM or the flash, depending on a boot-select input. After a one-shot remap command it shows the core SRAM, and it stays that way until reset. The memory that slot 0 shows can still be reached at its own home slot at the same time.

The default map is:
- flash: 64 KB in slot 1
- core SRAM: 4 KB in slot 2
- backup SRAM: 2 KB in slot 3
- ROM: 12 KB in slot 4

Because the core SRAM slot is followed directly by the backup SRAM slot, the top 4 KB of slot 2 and the bottom of slot 3 together form one contiguous 6 KB window.

Top module: `remap_addr_decoder`

## Requirements
- R1: With `valid` high, an address whose slot field `addr[27:20]` equals 1, 2, 3 or 4 drives `memSel` one-hot on the home memory. The `memSel` bits are: bit 0 flash, bit 1 core SRAM, bit 2 backup SRAM, bit 3 ROM. In this case `abort` is low.
- R2: For a power-of-two memory, `memOffset` equals `addr[19:0]` modulo the memory size. Every multiple of the size within the slot therefore aliases to the same location.
- R3: The 12 KB ROM folds by modulo 12288. The final partial copy at the top of the slot decodes: address 0x4F_FFFF gives offset 4095.
- R4: With `valid` high, any slot from 5 to 255 raises `abort`, leaves `memSel` at zero and drives `memOffset` to zero.
- R5: Before remap, slot 0 selects the ROM when `bootRom` is 1 and the flash when it is 0. The offset is folded to the selected memory.
- R6: A one-cycle `remapCmd` pulse that is sampled on a rising clock edge sets the remap bit. From the next cycle on, slot 0 selects the core SRAM whatever the value of `bootRom`.
- R7: The remap bit stays set until reset, so further `remapCmd` pulses change nothing. Reset clears it, and slot 0 then follows `bootRom` again.
- R8: While a memory is aliased at slot 0, its home slot still selects it, with the same offset.
- R9: With `valid` low, `memSel`, `abort` and `memOffset` are all zero.
- R10: Addresses 0x2F_F000 to 0x2F_FFFF give core SRAM offsets 0 to 0xFFF. Address 0x30_0000 gives backup SRAM offset 0, which makes a contiguous 6 KB window.
- R11: At most one `memSel` bit is ever high, and `abort` never coincides with a select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the remap bit |
| rstN | input | 1 | Active-low asynchronous reset, clears the remap bit |
| addr | input | 28 | Byte address within the internal region |
| valid | input | 1 | Access strobe |
| bootRom | input | 1 | Boot select: 1 shows the ROM at slot 0 before remap, 0 shows the flash |
| remapCmd | input | 1 | One-shot command that switches slot 0 to the core SRAM |
| memSel | output | 4 | One-hot memory select (flash, core, backup, ROM) |
| memOffset | output | 20 | Address folded to the selected memory's size |
| abort | output | 1 | Access to an undefined slot |

## Verification
Two situations are hard to reach from the ports:
- **Slot 0 after remap.** The remap bit can only be set and never cleared, so the bench has to cover slot 0 with both `bootRom` values before and after a remap pulse. It then applies a reset mid-run to return to the earlier behaviour.
- **The ROM's last partial copy.** This copy sits at the very top of its slot and is almost never hit by uniform random addresses, so the bench drives directed addresses there.

Random addresses weighted toward the five defined slots and the first undefined slot cover aliasing at many multiples of each memory's size, both before and after remap.

// File: rtl/remap_dec_pkg.sv
package remap_dec_pkg;
  localparam int NUM_MEM    = 4;
  localparam int IDX_FLASH  = 0;
  localparam int IDX_CORE   = 1;
  localparam int IDX_BACKUP = 2;
  localparam int IDX_ROM    = 3;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic remapped;
    logic bootRom;
  } decCtrl_t;
endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import remap_dec_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     bootRom,
  input  logic     remapCmd,
  output decCtrl_t ctrlOut
);
  logic remapState;

  // One-way latch: only reset can clear it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      remapState <= 1'b0;
    else if (remapCmd)
      remapState <= 1'b1;
  end

  always_comb begin
    ctrlOut.remapped = remapState;
    ctrlOut.bootRom  = bootRom;
  end

  AST_REMAP_SET: assert property (@(posedge clk) disable iff (!rstN)
    remapCmd |=> remapState); // R6
  AST_REMAP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    remapState |=> remapState); // R7
endmodule

// File: rtl/remap_datapath.sv
module remap_datapath
  import remap_dec_pkg::*;
#(
  parameter int ADDR_W       = 28,
  parameter int SLOT_LOG2    = 20,
  parameter int FLASH_BYTES  = 65536,
  parameter int CORE_BYTES   = 4096,
  parameter int BACKUP_BYTES = 2048,
  parameter int ROM_BYTES    = 12288,
  parameter int FLASH_SLOT   = 1,
  parameter int CORE_SLOT    = 2,
  parameter int BACKUP_SLOT  = 3,
  parameter int ROM_SLOT     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  decCtrl_t             ctrlIn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 valid,
  output logic [NUM_MEM-1:0]   memSel,
  output logic [SLOT_LOG2-1:0] memOffset,
  output logic                 abort
);
  localparam int SLOT_W = ADDR_W - SLOT_LOG2;
  localparam int IDX_W  = $clog2(NUM_MEM);
  localparam int unsigned MEM_BYTES [NUM_MEM] =
    '{FLASH_BYTES, CORE_BYTES, BACKUP_BYTES, ROM_BYTES};
  localparam int HOME_SLOT [NUM_MEM] =
    '{FLASH_SLOT, CORE_SLOT, BACKUP_SLOT, ROM_SLOT};

  logic [SLOT_W-1:0]    slotIdx;
  logic [SLOT_LOG2-1:0] lowAddr;
  logic [SLOT_LOG2-1:0] foldOff [NUM_MEM];
  logic [IDX_W-1:0]     tgtIdx;
  logic                 slotHit;

  assign slotIdx = addr[ADDR_W-1:SLOT_LOG2];
  assign lowAddr = addr[SLOT_LOG2-1:0];

  // Per-memory fold: a mask for power-of-two sizes, true modulo otherwise
  for (genvar g = 0; g < NUM_MEM; g++) begin : g_fold
    if ((MEM_BYTES[g] & (MEM_BYTES[g] - 1)) == 0) begin : g_pow2
      assign foldOff[g] = lowAddr & SLOT_LOG2'(MEM_BYTES[g] - 1);
    end else begin : g_mod
      assign foldOff[g] = SLOT_LOG2'(32'(lowAddr) % MEM_BYTES[g]);
    end
  end

  // Slot 0 alias, then the home slots
  always_comb begin
    slotHit = 1'b0;
    tgtIdx  = '0;
    if (slotIdx == '0) begin
      slotHit = 1'b1;
      if (ctrlIn.remapped)     tgtIdx = IDX_W'(IDX_CORE);
      else if (ctrlIn.bootRom) tgtIdx = IDX_W'(IDX_ROM);
      else                     tgtIdx = IDX_W'(IDX_FLASH);
    end else begin
      for (int m = 0; m < NUM_MEM; m++) begin
        if (slotIdx == SLOT_W'(HOME_SLOT[m])) begin
          slotHit = 1'b1;
          tgtIdx  = IDX_W'(m);
        end
      end
    end
  end

  always_comb begin
    memSel    = '0;
    memOffset = '0;
    abort     = 1'b0;
    if (valid) begin
      if (slotHit) begin
        memSel    = NUM_MEM'(1) << tgtIdx;
        memOffset = foldOff[tgtIdx];
      end else begin
        abort = 1'b1;
      end
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(memSel)); // R11
  AST_ABORT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    abort |-> (memSel == '0)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !valid |-> (memSel == '0 && !abort && memOffset == '0)); // R9
  AST_ROM_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    memSel[IDX_ROM] |-> (memOffset < SLOT_LOG2'(ROM_BYTES))); // R3
  AST_SLOT0_CORE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlIn.remapped && valid && slotIdx == '0) |-> memSel[IDX_CORE]); // R6
endmodule

// File: rtl/remap_addr_decoder.sv
module remap_addr_decoder
  import remap_dec_pkg::*;
#(
  parameter int ADDR_W       = 28,
  parameter int SLOT_LOG2    = 20,
  parameter int FLASH_BYTES  = 65536,
  parameter int CORE_BYTES   = 4096,
  parameter int BACKUP_BYTES = 2048,
  parameter int ROM_BYTES    = 12288,
  parameter int FLASH_SLOT   = 1,
  parameter int CORE_SLOT    = 2,
  parameter int BACKUP_SLOT  = 3,
  parameter int ROM_SLOT     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 valid,
  input  logic                 bootRom,
  input  logic                 remapCmd,
  output logic [NUM_MEM-1:0]   memSel,
  output logic [SLOT_LOG2-1:0] memOffset,
  output logic                 abort
);
  decCtrl_t decCtrl;

  remap_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bootRom  (bootRom),
    .remapCmd (remapCmd),
    .ctrlOut  (decCtrl)
  );

  remap_datapath #(
    .ADDR_W      (ADDR_W),
    .SLOT_LOG2   (SLOT_LOG2),
    .FLASH_BYTES (FLASH_BYTES),
    .CORE_BYTES  (CORE_BYTES),
    .BACKUP_BYTES(BACKUP_BYTES),
    .ROM_BYTES   (ROM_BYTES),
    .FLASH_SLOT  (FLASH_SLOT),
    .CORE_SLOT   (CORE_SLOT),
    .BACKUP_SLOT (BACKUP_SLOT),
    .ROM_SLOT    (ROM_SLOT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlIn   (decCtrl),
    .addr     (addr),
    .valid    (valid),
    .memSel   (memSel),
    .memOffset(memOffset),
    .abort    (abort)
  );
endmodule

// File: tb/remap_addr_decoder_bench.sv
module remap_addr_decoder_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [27:0] addr = '0;
  logic        valid = 1'b0;
  logic        bootRom = 1'b0;
  logic        remapCmd = 1'b0;
  logic [3:0]  memSel;
  logic [19:0] memOffset;
  logic        abort;

  int checks = 0;
  int failures = 0;
  bit remModel = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  remap_addr_decoder u_remap_addr_decoder (
    .clk(clk), .rstN(rstN), .addr(addr), .valid(valid), .bootRom(bootRom),
    .remapCmd(remapCmd), .memSel(memSel), .memOffset(memOffset), .abort(abort)
  );

  // Reference model built from the requirements
  function automatic int memOf(logic [27:0] a, bit boot, bit rem);
    case (a[27:20])
      8'd0: return rem ? 1 : (boot ? 3 : 0);
      8'd1: return 0;
      8'd2: return 1;
      8'd3: return 2;
      8'd4: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic int sizeOf(int m);
    case (m)
      0: return 65536;
      1: return 4096;
      2: return 2048;
      default: return 12288;
    endcase
  endfunction

  task automatic checkAccess(input logic [27:0] a, input bit v, input bit boot,
                             input string tag);
    int          m;
    logic [3:0]  eSel;
    logic [19:0] eOff;
    logic        eAbort;
    @(negedge clk);
    addr = a; valid = v; bootRom = boot;
    #(PERIOD/4);
    m = memOf(a, boot, remModel);
    eSel = '0; eOff = '0; eAbort = 1'b0;
    if (v) begin
      if (m < 0) eAbort = 1'b1;
      else begin
        eSel = 4'(1 << m);
        eOff = 20'(int'(a[19:0]) % sizeOf(m));
      end
    end
    checks++;
    if (memSel !== eSel || memOffset !== eOff || abort !== eAbort) begin
      failures++;
      $display("FAIL %s addr=%h sel=%b off=%h abort=%b expected sel=%b off=%h abort=%b",
               tag, a, memSel, memOffset, abort, eSel, eOff, eAbort);
    end
  endtask

  task automatic pulseRemap();
    @(negedge clk); remapCmd = 1'b1;
    @(negedge clk); remapCmd = 1'b0;
    remModel = 1'b1;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; remapCmd = 1'b0;
    @(negedge clk); rstN = 1'b1;
    remModel = 1'b0;
  endtask

  task automatic randomPhase(input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0]  s;
      logic [27:0] a;
      s = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 6);
      a = {s, 20'($urandom)};
      checkAccess(a, ($urandom % 8) != 0, 1'($urandom), "R2 random");
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // Reset state / idle
    checkAccess(28'h010_0000, 1'b0, 1'b0, "R9 idle after reset");
    checkAccess(28'h500_0000, 1'b0, 1'b1, "R9 idle undefined slot");
    // Home slots
    checkAccess(28'h010_0000, 1'b1, 1'b0, "R1 flash home");
    checkAccess(28'h020_0000, 1'b1, 1'b0, "R1 core home");
    checkAccess(28'h030_0000, 1'b1, 1'b0, "R1 backup home");
    checkAccess(28'h040_0000, 1'b1, 1'b0, "R1 rom home");
    // Aliasing at multiples of size
    for (int k = 0; k < 16; k++) begin
      checkAccess(28'h010_0000 + 28'(k * 65536 + 'h123), 1'b1, 1'b0, "R2 flash alias");
      checkAccess(28'h020_0000 + 28'(k * 4096 * 13 + 'h10), 1'b1, 1'b0, "R2 core alias");
      checkAccess(28'h030_0000 + 28'(k * 2048 * 29 + 'h7ff), 1'b1, 1'b0, "R2 backup alias");
    end
    // ROM non-power-of-two folding
    checkAccess(28'h040_3000, 1'b1, 1'b0, "R3 rom second copy");
    checkAccess(28'h04F_F000, 1'b1, 1'b0, "R3 rom partial copy");
    checkAccess(28'h04F_FFFF, 1'b1, 1'b0, "R3 rom last byte");
    // Undefined slots
    checkAccess(28'h050_0000, 1'b1, 1'b0, "R4 first undefined");
    checkAccess(28'h800_1234, 1'b1, 1'b1, "R4 mid undefined");
    checkAccess(28'hFFF_FFFF, 1'b1, 1'b0, "R4 top undefined");
    // Slot 0 before remap
    checkAccess(28'h000_0000, 1'b1, 1'b0, "R5 boot flash");
    checkAccess(28'h00F_FFFF, 1'b1, 1'b1, "R5 boot rom top");
    checkAccess(28'h000_4567, 1'b1, 1'b1, "R5 boot rom");
    // Contiguous window
    checkAccess(28'h02F_F000, 1'b1, 1'b0, "R10 window start");
    checkAccess(28'h02F_FFFF, 1'b1, 1'b0, "R10 window core end");
    checkAccess(28'h030_0000, 1'b1, 1'b0, "R10 window backup start");
    randomPhase(800);
    // Remap
    pulseRemap();
    checkAccess(28'h000_0abc, 1'b1, 1'b0, "R6 core at slot0 boot0");
    checkAccess(28'h00F_FFFF, 1'b1, 1'b1, "R6 core at slot0 boot1");
    checkAccess(28'h020_0abc, 1'b1, 1'b1, "R8 core home while aliased");
    checkAccess(28'h010_0abc, 1'b1, 1'b0, "R8 flash home after remap");
    checkAccess(28'h040_0abc, 1'b1, 1'b1, "R8 rom home after remap");
    checkAccess(28'h000_0000, 1'b0, 1'b1, "R9 idle after remap");
    pulseRemap();
    checkAccess(28'h000_0100, 1'b1, 1'b1, "R7 second pulse sticky");
    randomPhase(800);
    doReset();
    checkAccess(28'h000_0100, 1'b1, 1'b1, "R7 reset restores rom alias");
    checkAccess(28'h000_0100, 1'b1, 1'b0, "R7 reset restores flash alias");
    checkAccess(28'h050_0000, 1'b1, 1'b0, "R11 abort without select");
    randomPhase(400);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule